// File: doc/BRIEF.md
# Priority Interrupt Acceptance Unit

This block decides, cycle by cycle, whether an interrupt is taken. Three request channels feed it: a non-maskable request, a software trap request that carries a trap number, and one maskable request. The maskable request has already been arbitrated upstream and carries a 3-bit priority and a vector number. The block compares the maskable request against the processor's enable flag and its current 3-bit priority level. When it takes a request, it reports which source won and the vector number. It also reports the status word the processor must adopt (enable flag, stack-select flag, priority level) and the status word that was in force before, so the processor can save it for the return.

The three request channels follow valid/ready rules. Each requester raises its valid and keeps valid and payload stable until it sees ready. Ready rises only on the channel that is taken, in the same cycle as the decision, and a channel that is not taken simply waits. The acceptance result is a one-cycle pulse, `acc_valid`, one clock after the ready. It has no back-pressure, because the processor must act on it. The processor keeps the status word itself and drives it back on the `cur_*` inputs.

The processor must present the updated status on `cur_*` by the cycle after the pulse. The block does not accept any request during the pulse cycle, to give that feedback time to settle.

Top module: `irq_accept_unit`

## Requirements
- R1: During reset and after it, `acc_valid`, `acc_src`, `acc_vec`, all `new_*` and all `old_*` outputs are 0. No ready is raised while every valid is 0.
- R2: A maskable request is taken only when `cur_ien` is 1 and `mreq_prio` is strictly greater than `cur_ipl`. An equal priority, a priority of 0, or `cur_ien` = 0 leaves it waiting.
- R3: When a maskable request is taken, the results are: `acc_src` = 1, `acc_vec` = `mreq_vec`, `new_ipl` = `mreq_prio`, `new_ien` = 0 and `new_stk` = 0.
- R4: A non-maskable request is taken whatever `cur_ien` and `cur_ipl` are. It wins over both other channels. The results are: `acc_src` = 3, `acc_vec` = `NMI_VEC` (63 by default), `new_ipl` = 7, `new_ien` = 0 and `new_stk` = 0.
- R5: A software trap is taken whatever `cur_ien` and `cur_ipl` are. It wins over a maskable request and loses to a non-maskable one. The results are: `acc_src` = 2, `acc_vec` = `swi_num`, `new_ien` = 0 and `new_ipl` = `cur_ipl`.
- R6: For a software trap numbered below `SWI_SPLIT` (32 by default), `new_stk` is 0. For numbers from `SWI_SPLIT` upward, `new_stk` equals `cur_stk`.
- R7: With each acceptance, `old_ien`, `old_stk` and `old_ipl` carry the `cur_*` values of the decision cycle.
- R8: Ready rises on at most one channel per cycle, and only on a channel whose valid is high. `acc_valid` is high in the cycle right after that ready, and only then.
- R9: No channel is given ready in a cycle where `acc_valid` is high. A request still pending then is taken no earlier than the next cycle.
- R10: In cycles without an acceptance, `acc_src`, `acc_vec` and all `new_*` and `old_*` outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| nmi_valid | input | 1 | Non-maskable request pending |
| nmi_ready | output | 1 | Non-maskable request taken this cycle |
| swi_valid | input | 1 | Software trap pending |
| swi_num | input | VEC_W | Software trap number |
| swi_ready | output | 1 | Software trap taken this cycle |
| mreq_valid | input | 1 | Maskable request pending |
| mreq_prio | input | LVL_W | Maskable request priority |
| mreq_vec | input | VEC_W | Maskable request vector number |
| mreq_ready | output | 1 | Maskable request taken this cycle |
| cur_ien | input | 1 | Current interrupt enable flag |
| cur_stk | input | 1 | Current stack-select flag (0 = interrupt stack) |
| cur_ipl | input | LVL_W | Current processor priority level |
| acc_valid | output | 1 | One-cycle acceptance pulse |
| acc_src | output | 2 | Winning source: 1 maskable, 2 software, 3 non-maskable |
| acc_vec | output | VEC_W | Vector number of the accepted request |
| new_ien | output | 1 | Enable flag to adopt |
| new_stk | output | 1 | Stack-select flag to adopt |
| new_ipl | output | LVL_W | Priority level to adopt |
| old_ien | output | 1 | Enable flag before acceptance |
| old_stk | output | 1 | Stack-select flag before acceptance |
| old_ipl | output | LVL_W | Priority level before acceptance |

## Verification
The hardest case to reach from the ports is the lock-out cycle. A request must be pending exactly while the acceptance pulse is high, and the status inputs must be left stale on purpose. The stimulus does this by keeping a maskable request valid across its own acceptance, so that it lands in the pulse cycle. It then checks that ready drops there and rises again one cycle later. Three-way contention and the two sides of the trap-number split for stack select are driven from a vector table that sets all channels and the status inputs in the same cycle.

// File: rtl/irq_accept_pkg.sv
`timescale 1ns/1ps
package irq_accept_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MASK = 2'd1,
    SRC_SWI  = 2'd2,
    SRC_NMI  = 2'd3
  } src_e;
endpackage

// File: rtl/irq_level_gate.sv
`timescale 1ns/1ps
module irq_level_gate #(
  parameter int LVL_W = 3
) (
  input  logic             m_valid,
  input  logic [LVL_W-1:0] m_prio,
  input  logic             ien,
  input  logic [LVL_W-1:0] ipl,
  output logic             eligible
);
  // strictly-greater compare; a level-0 request can never pass
  always_comb eligible = m_valid && ien && (m_prio > ipl);
endmodule

// File: rtl/irq_src_pick.sv
`timescale 1ns/1ps
module irq_src_pick
  import irq_accept_pkg::*;
(
  input  logic nmi_valid,
  input  logic swi_valid,
  input  logic mask_ok,
  input  logic lockout,
  output src_e pick,
  output logic nmi_ready,
  output logic swi_ready,
  output logic mreq_ready
);
  always_comb begin
    pick = SRC_NONE;
    if (!lockout) begin
      if (nmi_valid)      pick = SRC_NMI;
      else if (swi_valid) pick = SRC_SWI;
      else if (mask_ok)   pick = SRC_MASK;
    end
  end

  always_comb begin
    nmi_ready  = (pick == SRC_NMI);
    swi_ready  = (pick == SRC_SWI);
    mreq_ready = (pick == SRC_MASK);
  end
endmodule

// File: rtl/irq_status_upd.sv
`timescale 1ns/1ps
module irq_status_upd
  import irq_accept_pkg::*;
#(
  parameter int VEC_W     = 6,
  parameter int LVL_W     = 3,
  parameter int SWI_SPLIT = 32,
  parameter int NMI_VEC   = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_e             pick,
  input  logic [VEC_W-1:0] m_vec,
  input  logic [LVL_W-1:0] m_prio,
  input  logic [VEC_W-1:0] swi_num,
  input  logic             cur_ien,
  input  logic             cur_stk,
  input  logic [LVL_W-1:0] cur_ipl,
  output logic             acc_valid,
  output logic [1:0]       acc_src,
  output logic [VEC_W-1:0] acc_vec,
  output logic             new_ien,
  output logic             new_stk,
  output logic [LVL_W-1:0] new_ipl,
  output logic             old_ien,
  output logic             old_stk,
  output logic [LVL_W-1:0] old_ipl
);
  localparam int NUM_CNT   = 1 << VEC_W;
  localparam int SPLIT_CAP = (SWI_SPLIT > NUM_CNT) ? NUM_CNT : SWI_SPLIT;
  localparam logic [VEC_W:0]   SPLIT_V   = SPLIT_CAP[VEC_W:0];
  localparam logic [VEC_W-1:0] NMI_VEC_V = NMI_VEC[VEC_W-1:0];

  logic swi_low;

  generate
    if (SPLIT_CAP == 0) begin : g_never_low
      assign swi_low = 1'b0;
    end else if (SPLIT_CAP == NUM_CNT) begin : g_always_low
      assign swi_low = 1'b1;
    end else begin : g_cmp_low
      assign swi_low = ({1'b0, swi_num} < SPLIT_V);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_src   <= SRC_NONE;
      acc_vec   <= '0;
      new_ien   <= 1'b0;
      new_stk   <= 1'b0;
      new_ipl   <= '0;
      old_ien   <= 1'b0;
      old_stk   <= 1'b0;
      old_ipl   <= '0;
    end else begin
      acc_valid <= (pick != SRC_NONE);
      if (pick != SRC_NONE) begin
        acc_src <= pick;
        old_ien <= cur_ien;
        old_stk <= cur_stk;
        old_ipl <= cur_ipl;
        new_ien <= 1'b0;
        unique case (pick)
          SRC_MASK: begin
            acc_vec <= m_vec;
            new_ipl <= m_prio;
            new_stk <= 1'b0;
          end
          SRC_SWI: begin
            acc_vec <= swi_num;
            new_ipl <= cur_ipl;
            new_stk <= swi_low ? 1'b0 : cur_stk;
          end
          default: begin
            acc_vec <= NMI_VEC_V;
            new_ipl <= '1;
            new_stk <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
`timescale 1ns/1ps
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int VEC_W     = 6,
  parameter int LVL_W     = 3,
  parameter int SWI_SPLIT = 32,
  parameter int NMI_VEC   = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_valid,
  output logic             nmi_ready,
  input  logic             swi_valid,
  input  logic [VEC_W-1:0] swi_num,
  output logic             swi_ready,
  input  logic             mreq_valid,
  input  logic [LVL_W-1:0] mreq_prio,
  input  logic [VEC_W-1:0] mreq_vec,
  output logic             mreq_ready,
  input  logic             cur_ien,
  input  logic             cur_stk,
  input  logic [LVL_W-1:0] cur_ipl,
  output logic             acc_valid,
  output logic [1:0]       acc_src,
  output logic [VEC_W-1:0] acc_vec,
  output logic             new_ien,
  output logic             new_stk,
  output logic [LVL_W-1:0] new_ipl,
  output logic             old_ien,
  output logic             old_stk,
  output logic [LVL_W-1:0] old_ipl
);
  logic mask_ok;
  src_e pick;

  irq_level_gate #(.LVL_W(LVL_W)) u_gate (
    .m_valid  (mreq_valid),
    .m_prio   (mreq_prio),
    .ien      (cur_ien),
    .ipl      (cur_ipl),
    .eligible (mask_ok)
  );

  irq_src_pick u_pick (
    .nmi_valid  (nmi_valid),
    .swi_valid  (swi_valid),
    .mask_ok    (mask_ok),
    .lockout    (acc_valid),
    .pick       (pick),
    .nmi_ready  (nmi_ready),
    .swi_ready  (swi_ready),
    .mreq_ready (mreq_ready)
  );

  irq_status_upd #(
    .VEC_W(VEC_W), .LVL_W(LVL_W), .SWI_SPLIT(SWI_SPLIT), .NMI_VEC(NMI_VEC)
  ) u_upd (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick      (pick),
    .m_vec     (mreq_vec),
    .m_prio    (mreq_prio),
    .swi_num   (swi_num),
    .cur_ien   (cur_ien),
    .cur_stk   (cur_stk),
    .cur_ipl   (cur_ipl),
    .acc_valid (acc_valid),
    .acc_src   (acc_src),
    .acc_vec   (acc_vec),
    .new_ien   (new_ien),
    .new_stk   (new_stk),
    .new_ipl   (new_ipl),
    .old_ien   (old_ien),
    .old_stk   (old_stk),
    .old_ipl   (old_ipl)
  );
endmodule

// File: rtl/irq_accept_chk.sv
`timescale 1ns/1ps
module irq_accept_chk #(
  parameter int VEC_W     = 6,
  parameter int LVL_W     = 3,
  parameter int SWI_SPLIT = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_valid,
  input logic             nmi_ready,
  input logic             swi_valid,
  input logic [VEC_W-1:0] swi_num,
  input logic             swi_ready,
  input logic             mreq_valid,
  input logic [LVL_W-1:0] mreq_prio,
  input logic             mreq_ready,
  input logic             cur_ien,
  input logic             cur_stk,
  input logic [LVL_W-1:0] cur_ipl,
  input logic             acc_valid,
  input logic             new_ien,
  input logic             new_stk,
  input logic [LVL_W-1:0] new_ipl,
  input logic [VEC_W-1:0] acc_vec
);
  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi_ready, swi_ready, mreq_ready})); // R8
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ready |-> nmi_valid) and (swi_ready |-> swi_valid) and (mreq_ready |-> mreq_valid)); // R8
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ready || swi_ready || mreq_ready) |=> acc_valid); // R8
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> !(nmi_ready || swi_ready || mreq_ready)); // R9
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_ready |-> (cur_ien && (mreq_prio > cur_ipl))); // R2
  AST_MASK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_ready |=> (new_ipl == $past(mreq_prio)) && !new_stk); // R3
  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_valid && !acc_valid) |-> nmi_ready); // R4
  AST_SWI_OVER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_valid && !nmi_valid && !acc_valid) |-> swi_ready); // R5
  AST_IEN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> !new_ien); // R3
  AST_SWI_STK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_ready && (int'(swi_num) >= SWI_SPLIT)) |=> (new_stk == $past(cur_stk))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_ready || swi_ready || mreq_ready) |=> ($stable(acc_vec) && $stable(new_ipl) && $stable(new_stk))); // R10
endmodule

bind irq_accept_unit irq_accept_chk #(
  .VEC_W(VEC_W), .LVL_W(LVL_W), .SWI_SPLIT(SWI_SPLIT)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .nmi_valid(nmi_valid), .nmi_ready(nmi_ready),
  .swi_valid(swi_valid), .swi_num(swi_num), .swi_ready(swi_ready),
  .mreq_valid(mreq_valid), .mreq_prio(mreq_prio), .mreq_ready(mreq_ready),
  .cur_ien(cur_ien), .cur_stk(cur_stk), .cur_ipl(cur_ipl),
  .acc_valid(acc_valid), .new_ien(new_ien), .new_stk(new_stk),
  .new_ipl(new_ipl), .acc_vec(acc_vec)
);

// File: tb/sim_irq_accept_unit.sv
`timescale 1ns/1ps
module sim_irq_accept_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic nmi_valid, swi_valid, mreq_valid, cur_ien, cur_stk;
  logic [5:0] swi_num, mreq_vec;
  logic [2:0] mreq_prio, cur_ipl;
  logic nmi_ready, swi_ready, mreq_ready, acc_valid;
  logic [1:0] acc_src;
  logic [5:0] acc_vec;
  logic new_ien, new_stk, old_ien, old_stk;
  logic [2:0] new_ipl, old_ipl;

  irq_accept_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .nmi_valid(nmi_valid), .nmi_ready(nmi_ready),
    .swi_valid(swi_valid), .swi_num(swi_num), .swi_ready(swi_ready),
    .mreq_valid(mreq_valid), .mreq_prio(mreq_prio), .mreq_vec(mreq_vec),
    .mreq_ready(mreq_ready),
    .cur_ien(cur_ien), .cur_stk(cur_stk), .cur_ipl(cur_ipl),
    .acc_valid(acc_valid), .acc_src(acc_src), .acc_vec(acc_vec),
    .new_ien(new_ien), .new_stk(new_stk), .new_ipl(new_ipl),
    .old_ien(old_ien), .old_stk(old_stk), .old_ipl(old_ipl)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stimulus: nmi sv snum mv mprio mvec ien ipl stk | expected: acc src vec ien stk ipl
  localparam int NROW = 15;
  localparam logic [36:0] TBL [NROW] = '{
    {1'b0,1'b0,6'd0,  1'b1,3'd5,6'd20, 1'b1,3'd3,1'b1, 1'b1,2'd1,6'd20,1'b0,1'b0,3'd5}, // R3
    {1'b0,1'b0,6'd0,  1'b1,3'd3,6'd11, 1'b1,3'd3,1'b1, 1'b0,2'd0,6'd0, 1'b0,1'b0,3'd0}, // R2 equal
    {1'b0,1'b0,6'd0,  1'b1,3'd4,6'd11, 1'b0,3'd3,1'b1, 1'b0,2'd0,6'd0, 1'b0,1'b0,3'd0}, // R2 disabled
    {1'b0,1'b0,6'd0,  1'b1,3'd0,6'd11, 1'b1,3'd0,1'b1, 1'b0,2'd0,6'd0, 1'b0,1'b0,3'd0}, // R2 level 0
    {1'b0,1'b0,6'd0,  1'b1,3'd7,6'd9,  1'b1,3'd6,1'b0, 1'b1,2'd1,6'd9, 1'b0,1'b0,3'd7}, // R3
    {1'b1,1'b0,6'd0,  1'b0,3'd0,6'd0,  1'b0,3'd7,1'b1, 1'b1,2'd3,6'd63,1'b0,1'b0,3'd7}, // R4
    {1'b1,1'b1,6'd7,  1'b1,3'd7,6'd12, 1'b1,3'd0,1'b1, 1'b1,2'd3,6'd63,1'b0,1'b0,3'd7}, // R4 contention
    {1'b0,1'b1,6'd5,  1'b0,3'd0,6'd0,  1'b0,3'd4,1'b1, 1'b1,2'd2,6'd5, 1'b0,1'b0,3'd4}, // R5 R6
    {1'b0,1'b1,6'd31, 1'b0,3'd0,6'd0,  1'b1,3'd2,1'b1, 1'b1,2'd2,6'd31,1'b0,1'b0,3'd2}, // R6 below
    {1'b0,1'b1,6'd32, 1'b0,3'd0,6'd0,  1'b1,3'd2,1'b1, 1'b1,2'd2,6'd32,1'b0,1'b1,3'd2}, // R6 at split
    {1'b0,1'b1,6'd40, 1'b1,3'd6,6'd3,  1'b1,3'd1,1'b1, 1'b1,2'd2,6'd40,1'b0,1'b1,3'd1}, // R5 over mask
    {1'b0,1'b1,6'd63, 1'b0,3'd0,6'd0,  1'b1,3'd5,1'b0, 1'b1,2'd2,6'd63,1'b0,1'b0,3'd5}, // R6 keep 0
    {1'b0,1'b0,6'd0,  1'b1,3'd1,6'd1,  1'b1,3'd0,1'b1, 1'b1,2'd1,6'd1, 1'b0,1'b0,3'd1}, // R3 lowest
    {1'b0,1'b0,6'd0,  1'b1,3'd2,6'd8,  1'b1,3'd7,1'b1, 1'b0,2'd0,6'd0, 1'b0,1'b0,3'd0}, // R2 top level
    {1'b0,1'b0,6'd0,  1'b0,3'd7,6'd8,  1'b1,3'd0,1'b1, 1'b0,2'd0,6'd0, 1'b0,1'b0,3'd0}  // R8 no valid
  };

  task automatic idle();
    nmi_valid = 0; swi_valid = 0; mreq_valid = 0;
    swi_num = 0; mreq_prio = 0; mreq_vec = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] last_src;
    logic [5:0] last_vec;
    logic       last_stk;
    logic [2:0] last_ipl;
    logic       last_oien, last_ostk;
    logic [2:0] last_oipl;
    idle();
    cur_ien = 0; cur_stk = 0; cur_ipl = 0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1 acc_valid in reset", acc_valid, 0);
    chk("R1 acc_vec in reset", acc_vec, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 acc_valid after reset", acc_valid, 0);
    chk("R1 new_ipl after reset", new_ipl, 0);
    chk("R1 old_ipl after reset", old_ipl, 0);
    chk("R1 readys idle", {nmi_ready, swi_ready, mreq_ready}, 0);
    last_src = 0; last_vec = 0; last_stk = 0; last_ipl = 0;
    last_oien = 0; last_ostk = 0; last_oipl = 0;

    for (int i = 0; i < NROW; i++) begin
      logic [36:0] r;
      logic [1:0]  es;
      r = TBL[i];
      @(negedge clk);
      nmi_valid = r[36]; swi_valid = r[35]; swi_num = r[34:29];
      mreq_valid = r[28]; mreq_prio = r[27:25]; mreq_vec = r[24:19];
      cur_ien = r[18]; cur_ipl = r[17:15]; cur_stk = r[14];
      es = r[12:11];
      #1;
      chk($sformatf("R8 row%0d nmi_ready", i), nmi_ready, int'(es == 2'd3));
      chk($sformatf("R8 row%0d swi_ready", i), swi_ready, int'(es == 2'd2));
      chk($sformatf("R2 row%0d mreq_ready", i), mreq_ready, int'(es == 2'd1));
      @(negedge clk);
      chk($sformatf("R8 row%0d acc_valid", i), acc_valid, int'(r[13]));
      if (r[13]) begin
        chk($sformatf("R3 row%0d acc_src", i), acc_src, es);
        chk($sformatf("R4 R5 row%0d acc_vec", i), acc_vec, r[10:5]);
        chk($sformatf("R3 row%0d new_ien", i), new_ien, r[4]);
        chk($sformatf("R6 row%0d new_stk", i), new_stk, r[3]);
        chk($sformatf("R5 row%0d new_ipl", i), new_ipl, r[2:0]);
        chk($sformatf("R7 row%0d old_ien", i), old_ien, r[18]);
        chk($sformatf("R7 row%0d old_ipl", i), old_ipl, r[17:15]);
        chk($sformatf("R7 row%0d old_stk", i), old_stk, r[14]);
        last_src = es; last_vec = r[10:5]; last_stk = r[3]; last_ipl = r[2:0];
        last_oien = r[18]; last_ostk = r[14]; last_oipl = r[17:15];
      end else begin
        chk($sformatf("R10 row%0d acc_src held", i), acc_src, last_src);
        chk($sformatf("R10 row%0d acc_vec held", i), acc_vec, last_vec);
        chk($sformatf("R10 row%0d new_stk held", i), new_stk, last_stk);
        chk($sformatf("R10 row%0d new_ipl held", i), new_ipl, last_ipl);
        chk($sformatf("R10 row%0d old_ien held", i), old_ien, last_oien);
        chk($sformatf("R10 row%0d old_stk held", i), old_stk, last_ostk);
        chk($sformatf("R10 row%0d old_ipl held", i), old_ipl, last_oipl);
      end
      idle();
    end

    // R9: request held across its own acceptance, stale status inputs
    @(negedge clk);
    mreq_valid = 1; mreq_prio = 3'd5; mreq_vec = 6'd17;
    cur_ien = 1; cur_ipl = 0; cur_stk = 1;
    #1;
    chk("R9 first take ready", mreq_ready, 1);
    @(negedge clk); #1;
    chk("R9 pulse present", acc_valid, 1);
    chk("R9 no ready during pulse", mreq_ready, 0);
    @(negedge clk); #1;
    chk("R9 pulse gone", acc_valid, 0);
    chk("R9 ready after lockout", mreq_ready, 1);
    nmi_valid = 1;
    #0.5;
    chk("R4 nmi preempts held mask", {nmi_ready, mreq_ready}, 2);
    @(negedge clk); #1;
    chk("R9 nmi lockout", nmi_ready, 0);
    chk("R4 nmi src", acc_src, 3);
    idle();
    @(negedge clk);

    // R1: reset mid-run clears results
    rst_n = 0;
    @(negedge clk);
    chk("R1 vec cleared by reset", acc_vec, 0);
    chk("R1 new_ipl cleared by reset", new_ipl, 0);
    chk("R1 src cleared by reset", acc_src, 0);
    rst_n = 1;
    @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule